// File: doc/BRIEF.md
# Camera Receiver Link Startup Sequencer

This controller takes a serial camera receiver link from fully held in reset to a running high-speed link, and takes it back down. A start request picks a PHY frequency-range code from the per-lane bit rate and writes it through a simple request/acknowledge PHY test port. It then loads the lane-count register and releases the PHY shutdown, the PHY reset and the controller reset together. It waits for the clock lane and every active data lane to report stop state, raises the sensor-start request, and waits for the clock lane to report high-speed activity.

If the stop-state wait runs out of time, the sequencer sets a warning flag and carries on. A missing high-speed clock, a rate outside the table, an invalid lane count or an unanswered test-port write ends the attempt with the error flag set and the link rolled back. The done and error flags hold until the next start or stop request. A stop request always drops the sensor start and asserts all three resets. The PHY, the sensor and the register bus are modelled as plain ports.

Top module: `link_bringup_seq`

## Requirements
- R1: On start, the range code written on `tst_data_o` (test register `tst_addr_o` = 0x44) comes from the first table entry whose limit is strictly greater than the rate. With `rate_valid_i` low the rate is 849, giving 0x14. `tst_req_o` holds until `tst_ack_i` is sampled high. Sample points: 89→0x00, 90→0x20, 124→0x02, 125→0x22, 850→0x34, 999→0x74.
- R2: A rate of 1000 or more sets `error_o` on the first edge after start. No test write is made and all resets stay asserted (0).
- R3: After the test write, `nlanes_o` is loaded with the requested lane count minus one. A count of 0, above 4, or above `cfg_max_lanes_i` instead sets `error_o` with the resets still asserted.
- R4: The resets `shutdown_n_o`, `phy_rst_n_o` and `ctrl_rst_n_o` are released (1) together in the same cycle that `nlanes_o` is loaded.
- R5: The stop-state wait completes only when `phy_state_i` bit 10 and bits 4 to 4+L-1 (L = active lanes) are all 1 in the same cycle. Bits of inactive lanes are ignored.
- R6: Each wait restarts a counter on entry and times out after `timeout_i`+1 cycles in the state. A stop-state timeout sets `stop_warn_o` and still raises `sensor_start_o`.
- R7: `sensor_start_o` rises when the stop-state wait ends. When `phy_state_i` bit 8 is then seen high, `done_o` is set.
- R8: A high-speed clock timeout drops `sensor_start_o`, asserts all three resets and sets `error_o`.
- R9: A stop request, in any state, drops `sensor_start_o` and `tst_req_o`, asserts all three resets and clears `done_o`, `error_o` and `stop_warn_o` on the next edge.
- R10: A start request while a bring-up is running or the link is up is ignored. `done_o` and `error_o` stay set until the next start or stop.
- R11: If the test-port write is not acknowledged within the timeout, `error_o` is set and `tst_req_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Bring-up request (one cycle) |
| stop_i | input | 1 | Tear-down request (one cycle) |
| lanes_req_i | input | 3 | Requested active data lane count |
| cfg_max_lanes_i | input | 3 | Lane count wired on the board |
| rate_valid_i | input | 1 | Rate input is supplied |
| rate_mbps_i | input | 11 | Per-lane bit rate in Mbps |
| timeout_i | input | 16 | Wait timeout in cycles |
| phy_state_i | input | 16 | PHY status word |
| tst_ack_i | input | 1 | Test-port write acknowledge |
| tst_req_o | output | 1 | Test-port write request |
| tst_addr_o | output | 8 | Test register code |
| tst_data_o | output | 8 | Frequency-range code |
| nlanes_o | output | 2 | Lane-count register (lanes minus one) |
| shutdown_n_o | output | 1 | PHY shutdown, 0 = asserted |
| phy_rst_n_o | output | 1 | PHY reset, 0 = asserted |
| ctrl_rst_n_o | output | 1 | Controller reset, 0 = asserted |
| sensor_start_o | output | 1 | Sensor streaming request |
| done_o | output | 1 | Link up |
| error_o | output | 1 | Bring-up failed |
| stop_warn_o | output | 1 | Stop-state wait timed out |

## Verification
A wrong state register shows at the ports within one edge: the resets or sensor start change in the wrong order, or a wait ends before its condition is met. A broken timeout counter moves the warning or error edge by whole cycles, so the bench checks the exact cycle on each side of each expiry. A wrong range-table entry or mask bit shows up on the test-port data or as a premature sensor start at the first affected rate or lane pattern. The table boundaries are probed on both sides.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
    localparam int RATE_W     = 11;
    localparam int CODE_W     = 8;
    localparam int NUM_RANGES = 29;

    // Upper rate limit (exclusive) of each range and its PHY range code
    localparam logic [RATE_W-1:0] RANGE_LIMIT [NUM_RANGES] = '{
        11'd90,  11'd100, 11'd110, 11'd125, 11'd140, 11'd150, 11'd160, 11'd180,
        11'd200, 11'd210, 11'd240, 11'd250, 11'd270, 11'd300, 11'd330, 11'd360,
        11'd400, 11'd450, 11'd500, 11'd550, 11'd600, 11'd650, 11'd700, 11'd750,
        11'd800, 11'd850, 11'd900, 11'd950, 11'd1000
    };
    localparam logic [CODE_W-1:0] RANGE_CODE [NUM_RANGES] = '{
        8'h00, 8'h20, 8'h40, 8'h02, 8'h22, 8'h42, 8'h04, 8'h24,
        8'h44, 8'h06, 8'h26, 8'h46, 8'h08, 8'h28, 8'h48, 8'h2a,
        8'h4a, 8'h0c, 8'h2c, 8'h0e, 8'h2e, 8'h10, 8'h30, 8'h12,
        8'h32, 8'h14, 8'h34, 8'h54, 8'h74
    };

    typedef enum logic [2:0] {
        S_IDLE, S_TWR, S_LANES, S_WSTOP, S_WCLK, S_UP
    } seq_e;
endpackage

// File: rtl/range_sel.sv
module range_sel
    import lbs_pkg::*;
#(
    parameter int DEFAULT_RATE = 849
) (
    input  logic              rate_valid_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic [CODE_W-1:0] code_o,
    output logic              bad_o
);
    logic [RATE_W-1:0] rate_eff;

    always_comb begin
        rate_eff = rate_valid_i ? rate_i : RATE_W'(DEFAULT_RATE);
        code_o   = '0;
        bad_o    = 1'b1;
        // Walk downward so the lowest qualifying entry wins
        for (int i = NUM_RANGES - 1; i >= 0; i--) begin
            if (RANGE_LIMIT[i] > rate_eff) begin
                code_o = RANGE_CODE[i];
                bad_o  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/lane_mask.sv
module lane_mask #(
    parameter int MAX_LANES     = 4,
    parameter int PHY_W         = 16,
    parameter int DATA_STOP_LSB = 4,
    parameter int CLK_STOP_BIT  = 10,
    localparam int NLW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
    input  logic [NLW-1:0]   nlanes_m1_i,
    input  logic [PHY_W-1:0] phy_state_i,
    output logic             stop_ok_o
);
    logic [MAX_LANES-1:0] lane_ok;

    for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
        // Inactive lanes are treated as satisfied
        assign lane_ok[g] = (NLW'(g) > nlanes_m1_i) | phy_state_i[DATA_STOP_LSB + g];
    end

    assign stop_ok_o = (&lane_ok) & phy_state_i[CLK_STOP_BIT];
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign expired_o = (cnt_q >= limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (!expired_o)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import lbs_pkg::*;
#(
    parameter int MAX_LANES     = 4,
    parameter int TMO_W         = 16,
    parameter int PHY_W         = 16,
    parameter int DATA_STOP_LSB = 4,
    parameter int HS_CLK_BIT    = 8,
    parameter int CLK_STOP_BIT  = 10,
    parameter int TEST_CODE     = 8'h44,
    parameter int DEFAULT_RATE  = 849,
    localparam int LW  = $clog2(MAX_LANES + 1),
    localparam int NLW = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [LW-1:0]     lanes_req_i,
    input  logic [LW-1:0]     cfg_max_lanes_i,
    input  logic              rate_valid_i,
    input  logic [RATE_W-1:0] rate_mbps_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic [PHY_W-1:0]  phy_state_i,
    input  logic              tst_ack_i,
    output logic              tst_req_o,
    output logic [CODE_W-1:0] tst_addr_o,
    output logic [CODE_W-1:0] tst_data_o,
    output logic [NLW-1:0]    nlanes_o,
    output logic              shutdown_n_o,
    output logic              phy_rst_n_o,
    output logic              ctrl_rst_n_o,
    output logic              sensor_start_o,
    output logic              done_o,
    output logic              error_o,
    output logic              stop_warn_o
);
    typedef struct packed {
        seq_e              state;
        logic [NLW-1:0]    nlanes;
        logic              released;
        logic              sensor;
        logic              tst_req;
        logic [CODE_W-1:0] code;
        logic              done;
        logic              err;
        logic              warn;
    } seq_t;

    seq_t q, d;

    logic [CODE_W-1:0] rng_code;
    logic              rng_bad;
    logic              stop_ok;
    logic              tmr_clr;
    logic              expired;
    logic              lanes_ok;
    logic [LW-1:0]     lanes_m1;
    logic              unused_phy;

    assign unused_phy = ^phy_state_i;

    range_sel #(.DEFAULT_RATE(DEFAULT_RATE)) u_range (
        .rate_valid_i (rate_valid_i),
        .rate_i       (rate_mbps_i),
        .code_o       (rng_code),
        .bad_o        (rng_bad)
    );

    lane_mask #(
        .MAX_LANES     (MAX_LANES),
        .PHY_W         (PHY_W),
        .DATA_STOP_LSB (DATA_STOP_LSB),
        .CLK_STOP_BIT  (CLK_STOP_BIT)
    ) u_mask (
        .nlanes_m1_i (q.nlanes),
        .phy_state_i (phy_state_i),
        .stop_ok_o   (stop_ok)
    );

    wait_timer #(.W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .limit_i   (timeout_i),
        .expired_o (expired)
    );

    assign lanes_ok = (lanes_req_i != '0) &&
                      (lanes_req_i <= LW'(MAX_LANES)) &&
                      (lanes_req_i <= cfg_max_lanes_i);
    assign lanes_m1 = lanes_req_i - 1'b1;

    always_comb begin
        d = q;
        unique case (q.state)
            S_IDLE: begin
                if (start_i) begin
                    d.done = 1'b0;
                    d.err  = 1'b0;
                    d.warn = 1'b0;
                    if (rng_bad) begin
                        d.err = 1'b1;
                    end else begin
                        d.code    = rng_code;
                        d.tst_req = 1'b1;
                        d.state   = S_TWR;
                    end
                end
            end
            S_TWR: begin
                if (tst_ack_i) begin
                    d.tst_req = 1'b0;
                    d.state   = S_LANES;
                end else if (expired) begin
                    d.tst_req = 1'b0;
                    d.err     = 1'b1;
                    d.state   = S_IDLE;
                end
            end
            S_LANES: begin
                if (lanes_ok) begin
                    d.nlanes   = lanes_m1[NLW-1:0];
                    d.released = 1'b1;
                    d.state    = S_WSTOP;
                end else begin
                    d.err   = 1'b1;
                    d.state = S_IDLE;
                end
            end
            S_WSTOP: begin
                if (stop_ok) begin
                    d.sensor = 1'b1;
                    d.state  = S_WCLK;
                end else if (expired) begin
                    d.warn   = 1'b1;
                    d.sensor = 1'b1;
                    d.state  = S_WCLK;
                end
            end
            S_WCLK: begin
                if (phy_state_i[HS_CLK_BIT]) begin
                    d.done  = 1'b1;
                    d.state = S_UP;
                end else if (expired) begin
                    d.sensor   = 1'b0;
                    d.released = 1'b0;
                    d.err      = 1'b1;
                    d.state    = S_IDLE;
                end
            end
            S_UP: ;
            default: d.state = S_IDLE;
        endcase

        if (stop_i) begin
            d.state    = S_IDLE;
            d.sensor   = 1'b0;
            d.released = 1'b0;
            d.tst_req  = 1'b0;
            d.done     = 1'b0;
            d.err      = 1'b0;
            d.warn     = 1'b0;
        end

        tmr_clr = (d.state != q.state);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: S_IDLE, default: '0};
        else        q <= d;
    end

    assign tst_req_o      = q.tst_req;
    assign tst_addr_o     = CODE_W'(TEST_CODE);
    assign tst_data_o     = q.code;
    assign nlanes_o       = q.nlanes;
    assign shutdown_n_o   = q.released;
    assign phy_rst_n_o    = q.released;
    assign ctrl_rst_n_o   = q.released;
    assign sensor_start_o = q.sensor;
    assign done_o         = q.done;
    assign error_o        = q.err;
    assign stop_warn_o    = q.warn;
endmodule

// File: rtl/lbs_checker.sv
module lbs_checker #(
    parameter int LW  = 3,
    parameter int NLW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           stop_i,
    input logic [LW-1:0]  cfg_max_lanes_i,
    input logic           tst_req_o,
    input logic [7:0]     tst_data_o,
    input logic [NLW-1:0] nlanes_o,
    input logic           shutdown_n_o,
    input logic           ctrl_rst_n_o,
    input logic           sensor_start_o,
    input logic           done_o,
    input logic           error_o
);
    assert_data_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tst_req_o && $past(tst_req_o) |-> $stable(tst_data_o));

    assert_lanes_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rst_n_o) |-> (LW'(nlanes_o) < cfg_max_lanes_i));

    assert_sensor_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sensor_start_o |-> ctrl_rst_n_o);

    assert_error_rollback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> (!sensor_start_o && !shutdown_n_o));

    assert_stop_teardown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!sensor_start_o && !shutdown_n_o && !done_o && !error_o));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));
endmodule

bind link_bringup_seq lbs_checker #(.LW(LW), .NLW(NLW)) u_lbs_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .stop_i          (stop_i),
    .cfg_max_lanes_i (cfg_max_lanes_i),
    .tst_req_o       (tst_req_o),
    .tst_data_o      (tst_data_o),
    .nlanes_o        (nlanes_o),
    .shutdown_n_o    (shutdown_n_o),
    .ctrl_rst_n_o    (ctrl_rst_n_o),
    .sensor_start_o  (sensor_start_o),
    .done_o          (done_o),
    .error_o         (error_o)
);

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, stop_i = 1'b0;
    logic [2:0]  lanes_req_i = 3'd2, cfg_max_lanes_i = 3'd4;
    logic        rate_valid_i = 1'b0;
    logic [10:0] rate_mbps_i = '0;
    logic [15:0] timeout_i = 16'd5;
    logic [15:0] phy_state_i = '0;
    logic        tst_ack_i = 1'b0;
    logic        tst_req_o, shutdown_n_o, phy_rst_n_o, ctrl_rst_n_o;
    logic        sensor_start_o, done_o, error_o, stop_warn_o;
    logic [7:0]  tst_addr_o, tst_data_o;
    logic [1:0]  nlanes_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    link_bringup_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .lanes_req_i(lanes_req_i), .cfg_max_lanes_i(cfg_max_lanes_i),
        .rate_valid_i(rate_valid_i), .rate_mbps_i(rate_mbps_i),
        .timeout_i(timeout_i), .phy_state_i(phy_state_i), .tst_ack_i(tst_ack_i),
        .tst_req_o(tst_req_o), .tst_addr_o(tst_addr_o), .tst_data_o(tst_data_o),
        .nlanes_o(nlanes_o), .shutdown_n_o(shutdown_n_o), .phy_rst_n_o(phy_rst_n_o),
        .ctrl_rst_n_o(ctrl_rst_n_o), .sensor_start_o(sensor_start_o),
        .done_o(done_o), .error_o(error_o), .stop_warn_o(stop_warn_o)
    );

    // {rate_valid, rate, expected code, expected error}
    localparam int NV = 11;
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 11'd0,    8'h14, 1'b0},
        {1'b1, 11'd0,    8'h00, 1'b0},
        {1'b1, 11'd89,   8'h00, 1'b0},
        {1'b1, 11'd90,   8'h20, 1'b0},
        {1'b1, 11'd124,  8'h02, 1'b0},
        {1'b1, 11'd125,  8'h22, 1'b0},
        {1'b1, 11'd849,  8'h14, 1'b0},
        {1'b1, 11'd850,  8'h34, 1'b0},
        {1'b1, 11'd999,  8'h74, 1'b0},
        {1'b1, 11'd1000, 8'h00, 1'b1},
        {1'b1, 11'd2047, 8'h00, 1'b1}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] rst_bits();
        return {shutdown_n_o, phy_rst_n_o, ctrl_rst_n_o};
    endfunction

    task automatic pulse_stop();
        stop_i = 1'b1; step(); stop_i = 1'b0;
    endtask

    // Start, acknowledge test write, enter stop-state wait
    task automatic to_wstop();
        start_i = 1'b1; step(); start_i = 1'b0;
        tst_ack_i = 1'b1; step(); tst_ack_i = 1'b0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R9 reset resets asserted", 32'(rst_bits()), 32'h0);
        chk("R9 reset flags", 32'({done_o, error_o, stop_warn_o, sensor_start_o, tst_req_o}), 32'h0);

        // Rate table walk
        for (int i = 0; i < NV; i++) begin
            rate_valid_i = VEC[i][20];
            rate_mbps_i  = VEC[i][19:9];
            start_i = 1'b1; step(); start_i = 1'b0;
            if (VEC[i][0]) begin
                chk("R2 rate error", 32'(error_o), 32'h1);
                chk("R2 no test write", 32'({tst_req_o, rst_bits()}), 32'h0);
            end else begin
                chk("R1 test request", 32'(tst_req_o), 32'h1);
                chk("R1 range code", 32'(tst_data_o), 32'(VEC[i][8:1]));
                chk("R1 test address", 32'(tst_addr_o), 32'h44);
            end
            pulse_stop();
            chk("R9 stop clears", 32'({tst_req_o, error_o}), 32'h0);
        end
        rate_valid_i = 1'b0;

        // Normal bring-up, 2 lanes
        lanes_req_i = 3'd2; timeout_i = 16'd5; phy_state_i = '0;
        start_i = 1'b1; step(); start_i = 1'b0;
        step();
        chk("R1 request held without ack", 32'(tst_req_o), 32'h1);
        tst_ack_i = 1'b1; step(); tst_ack_i = 1'b0;
        chk("R1 request drops after ack", 32'(tst_req_o), 32'h0);
        chk("R4 resets held before lane load", 32'(rst_bits()), 32'h0);
        step();
        chk("R3 lane register", 32'(nlanes_o), 32'h1);
        chk("R4 resets released", 32'(rst_bits()), 32'h7);
        phy_state_i = 16'h0410;        // lane 1 not yet in stop state
        step(); step();
        chk("R5 partial mask waits", 32'(sensor_start_o), 32'h0);
        phy_state_i = 16'h0430;        // clock + lanes 0,1 only
        step();
        chk("R7 sensor start raised", 32'(sensor_start_o), 32'h1);
        chk("R5 no warning", 32'(stop_warn_o), 32'h0);
        step();
        chk("R7 waits for hs clock", 32'(done_o), 32'h0);
        phy_state_i = 16'h0530;
        step();
        chk("R7 done", 32'(done_o), 32'h1);
        start_i = 1'b1; step(); start_i = 1'b0;
        step();
        chk("R10 start ignored while up", 32'({done_o, sensor_start_o, tst_req_o}), 32'h6);
        pulse_stop();
        chk("R9 stop tears down", 32'({rst_bits(), sensor_start_o, done_o}), 32'h0);

        // Stop-state timeout then clock timeout, 1 lane
        lanes_req_i = 3'd1; timeout_i = 16'd3; phy_state_i = 16'h00E0;
        to_wstop();
        chk("R3 one lane", 32'(nlanes_o), 32'h0);
        step(); step(); step();
        chk("R6 before stop timeout", 32'(sensor_start_o), 32'h0);
        step();
        chk("R6 timeout continues", 32'({stop_warn_o, sensor_start_o}), 32'h3);
        step();
        start_i = 1'b1; step(); start_i = 1'b0;
        step();
        chk("R8 before clock timeout", 32'({sensor_start_o, error_o}), 32'h2);
        step();
        chk("R8 clock timeout error", 32'(error_o), 32'h1);
        chk("R8 rollback", 32'({rst_bits(), sensor_start_o}), 32'h0);
        step(); step();
        chk("R10 error held", 32'(error_o), 32'h1);

        // Inactive lane bits ignored: 1 lane, only clock + lane 0 stop
        phy_state_i = 16'h0410;
        to_wstop();
        chk("R10 new start clears error", 32'(error_o), 32'h0);
        step();
        chk("R5 inactive lanes ignored", 32'({sensor_start_o, stop_warn_o}), 32'h2);
        pulse_stop();

        // Lane count errors
        lanes_req_i = 3'd3; cfg_max_lanes_i = 3'd2;
        to_wstop();
        chk("R3 above configured max", 32'({error_o, rst_bits()}), 32'h8);
        lanes_req_i = 3'd0; cfg_max_lanes_i = 3'd4;
        to_wstop();
        chk("R3 zero lanes", 32'({error_o, rst_bits()}), 32'h8);
        lanes_req_i = 3'd5; cfg_max_lanes_i = 3'd7;
        to_wstop();
        chk("R3 above four lanes", 32'({error_o, rst_bits()}), 32'h8);
        lanes_req_i = 3'd4; cfg_max_lanes_i = 3'd4; phy_state_i = 16'h04F0;
        to_wstop();
        chk("R3 four lanes", 32'(nlanes_o), 32'h3);
        step();
        chk("R5 four lanes stop", 32'(sensor_start_o), 32'h1);
        pulse_stop();

        // Test-port ack timeout
        timeout_i = 16'd2;
        start_i = 1'b1; step(); start_i = 1'b0;
        step(); step();
        chk("R11 before ack timeout", 32'({tst_req_o, error_o}), 32'h2);
        step();
        chk("R11 ack timeout", 32'({tst_req_o, error_o}), 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule